// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This unit lets software on one core send an interrupt message to other cores in a system of up to eight cores. Software programs it through two 32-bit command words. The high word at offset 0x310 holds an 8-bit destination. The low word at offset 0x300 holds the vector, delivery mode, addressing mode, level, trigger and shorthand fields. A write to the low word starts the message.

When the message starts, the unit resolves the set of receiving cores. The set comes from one of three sources: a physical core number, a logical bitmask of candidate cores, or a shorthand that ignores the destination. The shorthands that involve the sender use the sender's core number, which is a static input. The result is held on a valid/ready output as a target bitmask with a vector and a delivery mode.

A status bit in the low word reads 1, and `busy_o` is high, for as long as a message waits for acceptance. Clustered logical addressing is not provided, and neither is arbitration among lowest-priority candidates.

Top module: `ipi_cmd_unit`

## Requirements
- R1: A write to offset 0x310 stores bits 31:24 as the destination. A read of 0x310 returns it in bits 31:24 with zeros elsewhere. This write never starts a message.
- R2: A write to offset 0x300 while idle stores these fields: vector 7:0, delivery mode 10:8, addressing mode 11, level 14, trigger 15 and shorthand 19:18. A read of 0x300 returns those fields, the delivery status in bit 12, and zeros elsewhere. On the next cycle the output carries the delivery mode that was written.
- R3: With shorthand 0 and addressing mode 0, the destination is a core number. A number below NUM_CORES selects exactly that one core. A larger number gives an empty target, and then no message is issued and the status bit stays 0.
- R4: With shorthand 0 and addressing mode 1, target bit c is destination bit c. An all-zero result issues no message.
- R5: The destination is ignored for the other shorthands. Shorthand 1 targets only the sender, shorthand 2 targets every core, and shorthand 3 targets every core except the sender.
- R6: A started message appears on `msg_valid_o` in the cycle after the write. Valid, target, vector and mode stay stable until a cycle with `msg_ready_i` high, and valid is low in the cycle after that. `busy_o` and status bit 12 equal `msg_valid_o`.
- R7: A write to 0x300 while a message is pending changes no stored field and starts nothing.
- R8: For delivery modes 2 (system management), 4 (non-maskable) and 5 (init) the vector driven out is 0. For modes 0 (fixed), 1 (lowest priority) and 6 (startup) the written vector is passed through.
- R9: The reserved delivery modes 3 and 7 produce no message.
- R10: Reads of any other offset return 0, and writes to other offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| self_id_i | input | ID_W | Core number of the sender, static |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write offset |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 12 | Register read offset |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| busy_o | output | 1 | A message is pending |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| msg_target_o | output | NUM_CORES | Bitmask of receiving cores |
| msg_vector_o | output | 8 | Interrupt vector |
| msg_mode_o | output | 3 | Delivery mode |

## Verification
The hardest case to reach is a low-word write that lands while a message is still held. This is the only situation where a command is dropped. To reach it, the bench keeps ready low while it issues a second command, and it then reads back the low word to show that the first command's fields survived. A random phase then mixes writes to either word with a ready line that is sometimes stalled. This makes launch, acceptance and ignored writes fall into the same and neighbouring cycles, and it also covers empty-target commands, which only show up as a missing valid pulse.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;

  localparam logic [11:0] OFF_LO = 12'h300;
  localparam logic [11:0] OFF_HI = 12'h310;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_RSV7   = 3'd7
  } dlv_mode_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } short_e;

  typedef struct packed {
    short_e    sh;
    logic      trig;
    logic      lvl;
    logic      dmode;
    dlv_mode_e mode;
    logic [7:0] vec;
  } lo_cmd_t;

  function automatic lo_cmd_t unpack_lo(input logic [31:0] w);
    lo_cmd_t c;
    c.sh    = short_e'(w[19:18]);
    c.trig  = w[15];
    c.lvl   = w[14];
    c.dmode = w[11];
    c.mode  = dlv_mode_e'(w[10:8]);
    c.vec   = w[7:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_lo(input lo_cmd_t c, input logic status);
    return {12'b0, c.sh, 2'b0, c.trig, c.lvl, 1'b0, status, c.dmode, c.mode, c.vec};
  endfunction

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [11:0] wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [11:0] rd_addr_i,
  output logic [31:0] rd_data_o,
  input  logic        busy_i,
  output logic [7:0]  dest_o,
  output logic        launch_o,
  output lo_cmd_t     launch_cmd_o
);

  logic [7:0] dest_q;
  lo_cmd_t    lo_q;
  logic       hi_wr, lo_wr;

  assign hi_wr        = wr_en_i && (wr_addr_i == OFF_HI);
  assign lo_wr        = wr_en_i && (wr_addr_i == OFF_LO);
  assign launch_o     = lo_wr && !busy_i;
  assign launch_cmd_o = unpack_lo(wr_data_i);
  assign dest_o       = dest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_q <= '0;
      lo_q   <= '0;
    end else begin
      if (hi_wr)    dest_q <= wr_data_i[31:24];
      if (launch_o) lo_q   <= launch_cmd_o;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      OFF_LO:  rd_data_o = pack_lo(lo_q, busy_i);
      OFF_HI:  rd_data_o = {dest_q, 24'b0};
      default: rd_data_o = '0;
    endcase
  end

  AST_LOCK_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && lo_wr |=> $stable(lo_q)); // R7

  AST_HI_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr |-> !launch_o); // R1

endmodule

// File: rtl/ipi_target_decode.sv
module ipi_target_decode
  import ipi_cmd_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int ID_W      = 3
) (
  input  short_e               sh_i,
  input  logic                 dmode_i,
  input  dlv_mode_e            mode_i,
  input  logic [7:0]           vec_i,
  input  logic [7:0]           dest_i,
  input  logic [ID_W-1:0]      self_id_i,
  output logic [NUM_CORES-1:0] mask_o,
  output logic [7:0]           vec_o
);

  logic mode_ok;
  assign mode_ok = (mode_i != DM_RSV3) && (mode_i != DM_RSV7);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic phys_hit, self_hit, sel;
    assign phys_hit = (dest_i == 8'(c));
    assign self_hit = (self_id_i == ID_W'(c));
    always_comb begin
      unique case (sh_i)
        SH_NONE:   sel = dmode_i ? dest_i[c] : phys_hit;
        SH_SELF:   sel = self_hit;
        SH_ALL:    sel = 1'b1;
        SH_OTHERS: sel = !self_hit;
        default:   sel = 1'b0;
      endcase
    end
    assign mask_o[c] = sel && mode_ok;
  end

  // vector is meaningless or must be zero for these modes
  always_comb begin
    unique case (mode_i)
      DM_SMI, DM_NMI, DM_INIT: vec_o = '0;
      default:                 vec_o = vec_i;
    endcase
  end

endmodule

// File: rtl/ipi_msg_issue.sv
module ipi_msg_issue
  import ipi_cmd_pkg::*;
#(
  parameter int NUM_CORES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 launch_i,
  input  logic [NUM_CORES-1:0] mask_i,
  input  logic [7:0]           vec_i,
  input  dlv_mode_e            mode_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [NUM_CORES-1:0] target_o,
  output logic [7:0]           vec_o,
  output logic [2:0]           mode_o,
  output logic                 busy_o
);

  logic                 valid_q;
  logic [NUM_CORES-1:0] tgt_q;
  logic [7:0]           vec_q;
  dlv_mode_e            mode_q;
  logic                 load;

  // empty target: status never rises, nothing issued
  assign load = launch_i && (mask_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tgt_q   <= '0;
      vec_q   <= '0;
      mode_q  <= DM_FIXED;
    end else if (load) begin
      valid_q <= 1'b1;
      tgt_q   <= mask_i;
      vec_q   <= vec_i;
      mode_q  <= mode_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign target_o = tgt_q;
  assign vec_o    = vec_q;
  assign mode_o   = mode_q;
  assign busy_o   = valid_q;

  AST_HOLD_UNTIL_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ready_i |=> valid_q && $stable(tgt_q) && $stable(vec_q) && $stable(mode_q)); // R6

  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && ready_i |=> !valid_q); // R6

  AST_NONEMPTY_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> tgt_q != '0); // R3

  AST_VEC_SCRUBBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && (mode_q == DM_SMI || mode_q == DM_NMI || mode_q == DM_INIT) |-> vec_q == '0); // R8

  AST_NO_RSV_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> mode_q != DM_RSV3 && mode_q != DM_RSV7); // R9

endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_cmd_pkg::*;
#(
  parameter  int NUM_CORES = 8,
  localparam int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ID_W-1:0]      self_id_i,
  input  logic                 wr_en_i,
  input  logic [11:0]          wr_addr_i,
  input  logic [31:0]          wr_data_i,
  input  logic [11:0]          rd_addr_i,
  output logic [31:0]          rd_data_o,
  output logic                 busy_o,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [NUM_CORES-1:0] msg_target_o,
  output logic [7:0]           msg_vector_o,
  output logic [2:0]           msg_mode_o
);

  logic [7:0]           dest;
  logic                 launch;
  lo_cmd_t              cmd;
  logic [NUM_CORES-1:0] mask;
  logic [7:0]           vec_eff;
  logic                 busy;

  ipi_cmd_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .busy_i       (busy),
    .dest_o       (dest),
    .launch_o     (launch),
    .launch_cmd_o (cmd)
  );

  ipi_target_decode #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_dec (
    .sh_i      (cmd.sh),
    .dmode_i   (cmd.dmode),
    .mode_i    (cmd.mode),
    .vec_i     (cmd.vec),
    .dest_i    (dest),
    .self_id_i (self_id_i),
    .mask_o    (mask),
    .vec_o     (vec_eff)
  );

  ipi_msg_issue #(.NUM_CORES(NUM_CORES)) u_iss (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .mask_i   (mask),
    .vec_i    (vec_eff),
    .mode_i   (cmd.mode),
    .ready_i  (msg_ready_i),
    .valid_o  (msg_valid_o),
    .target_o (msg_target_o),
    .vec_o    (msg_vector_o),
    .mode_o   (msg_mode_o),
    .busy_o   (busy)
  );

  assign busy_o = busy;

  AST_PHYS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch && cmd.sh == SH_NONE && !cmd.dmode |-> $onehot0(mask)); // R3

  AST_OTHERS_SKIP_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch && cmd.sh == SH_OTHERS |-> (mask & (NUM_CORES'(1) << self_id_i)) == '0); // R5

  AST_SELF_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch && cmd.sh == SH_SELF |-> $countones(mask) <= 1); // R5

  AST_BUSY_IS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == msg_valid_o); // R6

endmodule

// File: tb/sim_ipi_cmd_unit.sv
`timescale 1ns/1ps
module sim_ipi_cmd_unit;
  localparam int N    = 8;
  localparam int SELF = 5;

  logic        clk = 0, rst_n = 0;
  logic        we = 0, rdy = 0;
  logic [11:0] waddr = 0, raddr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rd;
  logic        busy, vld;
  logic [N-1:0] tgt;
  logic [7:0]  vec;
  logic [2:0]  mode;
  int rdy_sel = 2;  // 0 stall, 1 random, 2 always
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipi_cmd_unit #(.NUM_CORES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .self_id_i(3'(SELF)),
    .wr_en_i(we), .wr_addr_i(waddr), .wr_data_i(wdata),
    .rd_addr_i(raddr), .rd_data_o(rd), .busy_o(busy),
    .msg_valid_o(vld), .msg_ready_i(rdy), .msg_target_o(tgt),
    .msg_vector_o(vec), .msg_mode_o(mode));

  // reference model
  logic [7:0]  m_dest;
  logic [31:0] m_lo;
  logic        m_valid;
  logic [7:0]  m_tgt, m_vec;
  logic [2:0]  m_mode;

  function automatic logic [7:0] ref_mask(input logic [31:0] w, input logic [7:0] d);
    int md = int'(w[10:8]);
    if (md == 3 || md == 7) return 8'h00;
    case (w[19:18])
      2'd0: if (w[11]) return d; else return (d < N) ? 8'(1 << d) : 8'h00;
      2'd1: return 8'(1 << SELF);
      2'd2: return 8'hFF;
      default: return 8'hFF & ~8'(1 << SELF);
    endcase
  endfunction

  function automatic logic [7:0] ref_vec(input logic [31:0] w);
    int md = int'(w[10:8]);
    return (md == 2 || md == 4 || md == 5) ? 8'h00 : w[7:0];
  endfunction

  function automatic logic [31:0] ref_rd(input logic [11:0] a);
    if (a == 12'h300) return m_lo | (m_valid ? 32'h1000 : 32'h0);
    if (a == 12'h310) return {m_dest, 24'h0};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dest <= 0; m_lo <= 0; m_valid <= 0; m_tgt <= 0; m_vec <= 0; m_mode <= 0;
    end else begin
      if (m_valid && rdy) m_valid <= 0;
      if (we && waddr == 12'h310) m_dest <= wdata[31:24];
      if (we && waddr == 12'h300 && !m_valid) begin
        m_lo <= wdata & 32'h000C_CFFF;
        if (ref_mask(wdata, m_dest) != 0) begin
          m_valid <= 1;
          m_tgt   <= ref_mask(wdata, m_dest);
          m_vec   <= ref_vec(wdata);
          m_mode  <= wdata[10:8];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 valid", 32'(vld), 32'(m_valid));
    chk("R6 busy", 32'(busy), 32'(m_valid));
    if (m_valid) begin
      if (m_lo[19:18] != 0)  chk("R5 target", 32'(tgt), 32'(m_tgt));
      else if (m_lo[11])     chk("R4 target", 32'(tgt), 32'(m_tgt));
      else                   chk("R3 target", 32'(tgt), 32'(m_tgt));
      chk("R8 vector", 32'(vec), 32'(m_vec));
      chk("R2 mode", 32'(mode), 32'(m_mode));
    end
    if (raddr == 12'h300)      chk("R2 read", rd, ref_rd(raddr));
    else if (raddr == 12'h310) chk("R1 read", rd, ref_rd(raddr));
    else                       chk("R10 read", rd, ref_rd(raddr));
  end

  always @(negedge clk) begin
    #1;
    case (rdy_sel)
      0: rdy = 0;
      1: rdy = ($urandom_range(0, 2) == 0);
      default: rdy = 1;
    endcase
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1 we = 1; waddr = a; wdata = d;
    @(negedge clk); #1 we = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic finish_run;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle(1);
    raddr = 12'h300; #1;
    chk("R2 reset read", rd, 32'h0);
    chk("R6 reset busy", 32'(busy), 32'h0);

    rdy_sel = 0;
    wr(12'h310, 32'h0300_0000);
    raddr = 12'h310; #1;
    chk("R1 dest read", rd, 32'h0300_0000);
    chk("R1 no launch", 32'(vld), 32'h0);

    wr(12'h300, 32'h0000_0041); #1;
    chk("R3 phys target", 32'(tgt), 32'h08);
    chk("R6 busy set", 32'(busy), 32'h1);
    wr(12'h300, 32'h0000_0642);  // ignored while busy
    raddr = 12'h300; #1;
    chk("R7 low kept", rd, 32'h0000_1041);
    chk("R7 target kept", 32'(tgt), 32'h08);
    rdy_sel = 2;
    settle(2);
    chk("R6 accepted", 32'(vld), 32'h0);

    rdy_sel = 0;
    wr(12'h310, 32'h0900_0000);
    wr(12'h300, 32'h0000_0077); #1;
    chk("R3 out of range", 32'(vld), 32'h0);
    chk("R3 status clear", rd, 32'h0000_0077);

    wr(12'h310, 32'h0200_0000);
    wr(12'h300, 32'h0000_0310); #1;
    chk("R9 reserved 3", 32'(vld), 32'h0);
    wr(12'h300, 32'h0000_0710); #1;
    chk("R9 reserved 7", 32'(vld), 32'h0);

    wr(12'h300, 32'h0000_0455); #1;
    chk("R8 nmi vec", 32'(vec), 32'h0);
    chk("R2 nmi mode", 32'(mode), 32'h4);
    rdy_sel = 2; settle(2); rdy_sel = 0;

    wr(12'h300, 32'h000C_0610); #1;
    chk("R5 others", 32'(tgt), 32'hDF);
    chk("R8 startup vec", 32'(vec), 32'h10);
    rdy_sel = 2; settle(2); rdy_sel = 0;

    wr(12'h300, 32'h0004_0010); #1;
    chk("R5 self", 32'(tgt), 32'h20);
    rdy_sel = 2; settle(2); rdy_sel = 0;

    wr(12'h310, 32'hA500_0000);
    wr(12'h300, 32'h0000_0810); #1;
    chk("R4 logical", 32'(tgt), 32'hA5);
    rdy_sel = 2; settle(2); rdy_sel = 0;

    wr(12'h310, 32'h0000_0000);
    wr(12'h300, 32'h0000_0810); #1;
    chk("R4 empty", 32'(vld), 32'h0);

    wr(12'h3E0, 32'hFFFF_FFFF);
    raddr = 12'h3E0; #1;
    chk("R10 other read", rd, 32'h0);
    chk("R10 no launch", 32'(vld), 32'h0);

    rdy_sel = 1;
    for (int i = 0; i < 600; i++) begin
      int pick = $urandom_range(0, 9);
      logic [31:0] d = $urandom;
      raddr = ($urandom_range(0, 1) == 0) ? 12'h300 : 12'h310;
      if (pick < 5)      wr(12'h300, d);
      else if (pick < 8) wr(12'h310, {d[31:24] & 8'h0F, d[23:0]});
      else if (pick < 9) wr(12'h314, d);
      else               settle(1);
    end
    rdy_sel = 2;
    settle(4);
    chk("R6 drained", 32'(vld), 32'h0);
    finish_run();
  end
endmodule